// File: doc/BRIEF.md
# Two-Level Priority Interrupt Arbiter

This block sits beside a small processor core and decides when a pending interrupt request may break into the running code. Each request line has its own enable bit and its own level bit, which selects the low or the high level. A global enable gates every line. The arbiter keeps one in-service flag per level. It raises a vector request toward the core, with the binary index of the chosen source, only when the candidate's level is strictly above every level whose flag is set.

The core pulses an acknowledge when it takes the vector. That pulse sets the flag of the vector's level. Saving the return address is the core's job. The core also reports two kinds of return. The dedicated return-from-interrupt clears the highest flag that is set. An ordinary subroutine return has no effect on the flags. Pushes, pops and stack pointer writes never reach this block. A routine that leaves through an ordinary return therefore keeps its level blocked. Higher levels still get through.

Top module: `prio_irq_ctl`

## Requirements
- R1: A synchronous reset, `rst` high at a clock edge, clears both in-service flags and drives `vec_req_o` low.
- R2: A request line counts only while `glb_en_i` is 1 and its own bit of `src_en_i` is 1.
- R3: A counted source with `src_hi_i` bit 1 is high level, otherwise low level. High-level candidates win over low-level ones. Within a level, the lowest-numbered source wins.
- R4: With only the low flag set, a counted high-level request raises `vec_req_o`.
- R5: A request at the level of a flag that is set is not accepted. This includes the source whose routine is running.
- R6: While the high flag is set, no low-level request is accepted.
- R7: `take_i` while `vec_req_o` is 1 sets the flag of the vector's level and drops `vec_req_o` at that same edge.
- R8: `reti_i` clears the high flag if it is set, otherwise the low flag. Only one flag is cleared.
- R9: `ret_i` has no effect on either flag.
- R10: If a low-level routine ends with `ret_i` in place of `reti_i`, low requests stay blocked and high requests are still accepted.
- R11: `vec_idx_o` does not change across an edge at which `take_i` is 1.
- R12: `vec_req_o` and `vec_idx_o` are registered. They reflect the inputs and flags of the previous clock edge, and `vec_idx_o` is the winning source number in binary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_i | input | N_SRC | Request line per source |
| src_hi_i | input | N_SRC | Level bit per source, 1 = high |
| src_en_i | input | N_SRC | Enable bit per source |
| glb_en_i | input | 1 | Global enable |
| take_i | input | 1 | Core takes the offered vector |
| reti_i | input | 1 | Core ran a return-from-interrupt |
| ret_i | input | 1 | Core ran an ordinary return |
| vec_req_o | output | 1 | Request to vector |
| vec_idx_o | output | IDX_W | Index of the offered source |

## Verification
The hardest states to reach are those where the two flags disagree with what the software believes. One case is a low routine left through an ordinary return while further requests keep arriving. Another is a return-from-interrupt that must strip only the top flag of a nested pair. From the ports these states are built in order. A low vector is taken. A high one preempts it and is taken too. Returns of both kinds are then issued, and requests at each level are probed after every step. Since the flags are not outputs, every flag state is read back as whether a fresh request at each level raises the vector request.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
   // In-service state, one bit per priority level
   typedef struct packed {
      logic hi;
      logic lo;
   } svc_t;

   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/prio_pick.sv
module prio_pick #(
   parameter int N_SRC = 8,
   localparam int IDX_W = prio_irq_pkg::idx_width(N_SRC)
) (
   input  logic [N_SRC-1:0] mask_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   generate
      if (N_SRC < 2) begin : g_bad
         $error("prio_pick needs at least two sources");
      end
   endgenerate

   // Lowest-numbered set bit wins: scan downward so the last hit is kept
   always_comb begin
      idx_o = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (mask_i[i]) idx_o = IDX_W'(i);
      end
   end

   assign any_o = |mask_i;
endmodule

// File: rtl/insvc_track.sv
module insvc_track
   import prio_irq_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic set_hi_i,
   input  logic set_lo_i,
   input  logic reti_i,
   input  logic ret_i,
   output svc_t svc_o
);
   svc_t svc_q, svc_n;

   always_comb begin
      svc_n = svc_q;
      if (reti_i) begin
         // Only the highest level in service is released
         if (svc_q.hi) svc_n.hi = 1'b0;
         else          svc_n.lo = 1'b0;
      end else if (ret_i) begin
         // Ordinary return leaves the state alone
         svc_n = svc_q;
      end
      if (set_hi_i) svc_n.hi = 1'b1;
      if (set_lo_i) svc_n.lo = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (rst) svc_q <= '0;
      else     svc_q <= svc_n;
   end

   assign svc_o = svc_q;
endmodule

// File: rtl/prio_irq_ctl.sv
module prio_irq_ctl
   import prio_irq_pkg::*;
#(
   parameter int N_SRC = 8,
   localparam int IDX_W = prio_irq_pkg::idx_width(N_SRC)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_SRC-1:0] req_i,
   input  logic [N_SRC-1:0] src_hi_i,
   input  logic [N_SRC-1:0] src_en_i,
   input  logic             glb_en_i,
   input  logic             take_i,
   input  logic             reti_i,
   input  logic             ret_i,
   output logic             vec_req_o,
   output logic [IDX_W-1:0] vec_idx_o
);
   generate
      if (N_SRC < 2 || N_SRC > 256) begin : g_bad
         $error("prio_irq_ctl: N_SRC out of range");
      end
   endgenerate

   logic [N_SRC-1:0] live, hi_mask, lo_mask;
   logic             hi_any, lo_any;
   logic [IDX_W-1:0] hi_idx, lo_idx;
   logic             cand_ok, cand_hi;
   logic [IDX_W-1:0] cand_idx;
   logic             vec_hi_q;
   logic             take_ok;
   svc_t             svc;
   logic             flag_hi, flag_lo;

   assign live    = req_i & src_en_i & {N_SRC{glb_en_i}};
   assign hi_mask = live & src_hi_i;
   assign lo_mask = live & ~src_hi_i;

   prio_pick #(.N_SRC(N_SRC)) u_pick_hi (.mask_i(hi_mask), .any_o(hi_any), .idx_o(hi_idx));
   prio_pick #(.N_SRC(N_SRC)) u_pick_lo (.mask_i(lo_mask), .any_o(lo_any), .idx_o(lo_idx));

   assign flag_hi = svc.hi;
   assign flag_lo = svc.lo;

   // Candidate must sit strictly above every level in service
   always_comb begin
      cand_hi  = hi_any;
      cand_idx = hi_any ? hi_idx : lo_idx;
      if (hi_any) cand_ok = !flag_hi;
      else        cand_ok = lo_any && !flag_hi && !flag_lo;
   end

   assign take_ok = take_i && vec_req_o;

   insvc_track u_track (
      .clk      (clk),
      .rst      (rst),
      .set_hi_i (take_ok && vec_hi_q),
      .set_lo_i (take_ok && !vec_hi_q),
      .reti_i   (reti_i),
      .ret_i    (ret_i),
      .svc_o    (svc)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         vec_req_o <= 1'b0;
         vec_idx_o <= '0;
         vec_hi_q  <= 1'b0;
      end else if (take_i) begin
         // Hold index and level while the core acknowledges
         vec_req_o <= 1'b0;
      end else begin
         vec_req_o <= cand_ok;
         vec_idx_o <= cand_idx;
         vec_hi_q  <= cand_hi;
      end
   end
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk #(
   parameter int N_SRC = 8,
   localparam int IDX_W = prio_irq_pkg::idx_width(N_SRC)
) (
   input logic             clk,
   input logic             rst,
   input logic             take_i,
   input logic             reti_i,
   input logic             ret_i,
   input logic             vec_req_o,
   input logic [IDX_W-1:0] vec_idx_o,
   input logic             vec_hi_q,
   input logic             flag_hi,
   input logic             flag_lo
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> !vec_req_o && !flag_hi && !flag_lo);

   // R6
   hi_blocks_all_chk: assert property (@(posedge clk) disable iff (rst) vec_req_o |-> !flag_hi);

   // R5
   lo_needs_idle_chk: assert property (@(posedge clk) disable iff (rst)
      (vec_req_o && !vec_hi_q) |-> (!flag_hi && !flag_lo));

   // R7
   take_sets_chk: assert property (@(posedge clk) disable iff (rst)
      (take_i && vec_req_o && !reti_i) |=> !vec_req_o && (vec_hi_q ? flag_hi : flag_lo));

   // R8
   reti_top_chk: assert property (@(posedge clk) disable iff (rst)
      (reti_i && !take_i && flag_hi) |=> !flag_hi && $stable(flag_lo));

   // R9
   ret_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ret_i && !reti_i && !take_i) |=> $stable(flag_hi) && $stable(flag_lo));

   // R11
   idx_hold_chk: assert property (@(posedge clk) disable iff (rst)
      take_i |=> $stable(vec_idx_o));
endmodule

bind prio_irq_ctl prio_irq_chk #(.N_SRC(N_SRC)) u_chk (
   .clk       (clk),
   .rst       (rst),
   .take_i    (take_i),
   .reti_i    (reti_i),
   .ret_i     (ret_i),
   .vec_req_o (vec_req_o),
   .vec_idx_o (vec_idx_o),
   .vec_hi_q  (vec_hi_q),
   .flag_hi   (flag_hi),
   .flag_lo   (flag_lo)
);

// File: tb/test_prio_irq_ctl.sv
module test_prio_irq_ctl;
   localparam int N = 5;
   localparam int IW = 3;
   localparam time CLK_P = 5ns;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [N-1:0]  req = '0, hi = '0, en = '1;
   logic          gen = 1'b1, take = 1'b0, reti = 1'b0, ret = 1'b0;
   logic          vreq;
   logic [IW-1:0] vidx;
   int            checks = 0, errors = 0;

   always #(CLK_P / 2) clk = ~clk;

   prio_irq_ctl #(.N_SRC(N)) i_prio_irq_ctl (
      .clk(clk), .rst(rst), .req_i(req), .src_hi_i(hi), .src_en_i(en),
      .glb_en_i(gen), .take_i(take), .reti_i(reti), .ret_i(ret),
      .vec_req_o(vreq), .vec_idx_o(vidx)
   );

   // {req, hi, en, gen, exp_req, exp_idx}
   localparam int TW = 3 * N + 2 + IW;
   localparam logic [TW-1:0] TBL [7] = '{
      {5'b00100, 5'b00000, 5'b11111, 1'b1, 1'b1, 3'd2},   // R12 single source
      {5'b10110, 5'b00000, 5'b11111, 1'b1, 1'b1, 3'd1},   // R3 lowest index
      {5'b10110, 5'b10000, 5'b11111, 1'b1, 1'b1, 3'd4},   // R3 high beats low
      {5'b10110, 5'b10000, 5'b01111, 1'b1, 1'b1, 3'd1},   // R2 own enable off
      {5'b10110, 5'b10100, 5'b11111, 1'b0, 1'b0, 3'd0},   // R2 global enable off
      {5'b11000, 5'b11000, 5'b11111, 1'b1, 1'b1, 3'd3},   // R3 within high level
      {5'b00000, 5'b00000, 5'b11111, 1'b1, 1'b0, 3'd0}    // R12 nothing pending
   };

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input string r, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", r, act, exp);
      end
   endtask

   task automatic pulse_take();
      take = 1'b1; step(); take = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1; req = '0; take = 0; reti = 0; ret = 0; gen = 1; en = '1;
      step(); step(); rst = 1'b0;
   endtask

   initial begin
      #(CLK_P * 200000);
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #1;
      do_reset();
      chk("R1 req after reset", 8'(vreq), 8'd0);

      for (int k = 0; k < 7; k++) begin
         {req, hi, en, gen} = TBL[k][TW-1:IW+1];
         step();
         chk("R2/R3/R12 table req", 8'(vreq), 8'(TBL[k][IW]));
         if (TBL[k][IW]) chk("R3/R12 table idx", 8'(vidx), 8'(TBL[k][IW-1:0]));
      end

      // Nested sequence: low taken, high preempts, returns
      do_reset();
      hi = 5'b10010;
      req = 5'b01000; step();
      chk("R12 low src3 offered", 8'(vreq), 8'd1);
      chk("R12 low src3 idx", 8'(vidx), 8'd3);
      req = 5'b01100;                     // change while acknowledging
      pulse_take();
      chk("R7 req drops on take", 8'(vreq), 8'd0);
      chk("R11 idx held on take", 8'(vidx), 8'd3);
      step();
      chk("R5 low blocked incl same source", 8'(vreq), 8'd0);
      req = 5'b11100; step();
      chk("R4 high preempts low", 8'(vreq), 8'd1);
      chk("R4 high idx", 8'(vidx), 8'd4);
      pulse_take();
      step();
      chk("R5 same source high blocked", 8'(vreq), 8'd0);
      req = 5'b01110; step();
      chk("R5 other high blocked", 8'(vreq), 8'd0);
      req = 5'b01100; step();
      chk("R6 low blocked under high", 8'(vreq), 8'd0);
      req = 5'b00110;
      ret = 1'b1; step(); ret = 1'b0; step();
      chk("R9 plain return keeps high flag", 8'(vreq), 8'd0);
      reti = 1'b1; step(); reti = 1'b0; step();
      chk("R8 reti frees high level", 8'(vreq), 8'd1);
      chk("R8 high src1 idx", 8'(vidx), 8'd1);
      req = 5'b01100; step();
      chk("R8 low flag kept by first reti", 8'(vreq), 8'd0);
      reti = 1'b1; step(); reti = 1'b0; step();
      chk("R8 second reti frees low", 8'(vreq), 8'd1);
      chk("R3 low src2 idx", 8'(vidx), 8'd2);

      // Low routine left by plain return
      do_reset();
      hi = 5'b00010;
      req = 5'b00001; step();
      pulse_take();
      req = 5'b00000;
      ret = 1'b1; step(); ret = 1'b0;
      req = 5'b00100; step(); step();
      chk("R10 low stays blocked", 8'(vreq), 8'd0);
      req = 5'b00110; step();
      chk("R10 high still accepted", 8'(vreq), 8'd1);
      chk("R10 high idx", 8'(vidx), 8'd1);

      // Reset while in service
      pulse_take();
      rst = 1'b1; step(); rst = 1'b0;
      chk("R1 req low in reset", 8'(vreq), 8'd0);
      req = 5'b00100; step();
      chk("R1 flags cleared", 8'(vreq), 8'd1);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule